// File: doc/BRIEF.md
# Translator Async Buffer Flush Register

This block is a single memory-mapped control and status word for an embedded transaction translator that holds several asynchronous transfer buffers. Software reads one bit to learn whether any of those buffers still holds data. It writes a second bit to ask for all of them to be flushed together. There is no per-buffer selection.

The flush does not cut into a transaction that is already running. After the request, the block waits until the buffer side drops its busy input. It then issues a single-cycle flush pulse and keeps the request bit set until every buffer reports empty. Software can therefore poll the request bit and treat its return to 0 as "flush finished". The register bus is a plain address / write-enable / write-data / read-data interface. Reads are combinational and writes take effect on the clock edge.

Top module: `tt_flush_reg`

## Requirements
- R1: After reset the request bit (bit 1) reads 0 and `flush_o` is low.
- R2: At byte address 0x15C, bit 0 of `rdata_o` is 1 when any bit of `buf_occ_i` is 1 and 0 when all are 0, in the same cycle.
- R3: A write at 0x15C with write-data bit 1 set, while no request is pending, makes bit 1 read 1 from the cycle after the write edge.
- R4: `flush_o` is high for exactly one cycle per request, only in a cycle where `xact_busy_i` is low; while `xact_busy_i` stays high the pulse is postponed.
- R5: After the flush pulse, bit 1 stays 1 while any `buf_occ_i` bit is set, and returns to 0 by itself within two clock edges once all are 0.
- R6: Writing 1 to bit 1 while a request is pending does not start a second flush pulse.
- R7: Writing 0 to bit 1 has no effect on the request bit and issues no flush.
- R8: Bits 31:2 at 0x15C read 0, any other address reads 0, and writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Register byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| buf_occ_i | input | 2 | Per-buffer occupancy flags from the buffers |
| xact_busy_i | input | 1 | Buffer side has a transaction in progress |
| flush_o | output | 1 | One-cycle flush command to all async buffers |

## Verification
The hardest case to reach is a request that arrives while a transaction is in flight and stays held for many cycles. The request bit must stay up and no pulse may leak out during that time. The bench raises `xact_busy_i` before the write and holds it for several cycles, sampling `flush_o` and the request bit each cycle. It then drops busy and expects the pulse in that same cycle. A second write during the drain phase, while the buffers are still occupied, covers the no-restart case.

// File: rtl/tt_flush_pkg.sv
package tt_flush_pkg;
  typedef enum logic [1:0] {
    FL_IDLE  = 2'd0,
    FL_WAIT  = 2'd1,  // request accepted, waiting for busy to drop
    FL_DRAIN = 2'd2   // pulse sent, waiting for buffers empty
  } fl_state_e;
endpackage

// File: rtl/tt_occ_reduce.sv
module tt_occ_reduce #(
  parameter int NUM_BUF = 2
) (
  input  logic [NUM_BUF-1:0] occ_i,
  output logic               any_o
);
  logic [NUM_BUF:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_BUF; g++) begin : g_or
    assign chain[g+1] = chain[g] | occ_i[g];
  end
  assign any_o = chain[NUM_BUF];
endmodule

// File: rtl/tt_reg_decode.sv
module tt_reg_decode #(
  parameter int          ADDR_W = 12,
  parameter int          DATA_W = 32,
  parameter logic [11:0] OFFSET = 12'h15C
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              status_i,
  input  logic              req_i,
  output logic              set_req_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(OFFSET);
  logic hit;
  assign hit       = (addr_i == HIT_ADDR);
  assign set_req_o = hit & we_i & wdata_i[1];
  always_comb begin
    rdata_o = '0;
    if (hit) begin
      rdata_o[0] = status_i;
      rdata_o[1] = req_i;
    end
  end
endmodule

// File: rtl/tt_flush_ctrl.sv
module tt_flush_ctrl
  import tt_flush_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_req_i,
  input  logic busy_i,
  input  logic any_occ_i,
  output logic req_o,
  output logic flush_o
);
  fl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FL_IDLE:  if (set_req_i) state_d = FL_WAIT;
      FL_WAIT:  if (!busy_i) state_d = FL_DRAIN;
      FL_DRAIN: if (!any_occ_i) state_d = FL_IDLE;
      default:  state_d = FL_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FL_IDLE;
    else         state_q <= state_d;
  end

  assign req_o   = (state_q != FL_IDLE);
  assign flush_o = (state_q == FL_WAIT) & ~busy_i;
endmodule

// File: rtl/tt_flush_reg.sv
module tt_flush_reg #(
  parameter int          ADDR_W  = 12,
  parameter int          DATA_W  = 32,
  parameter int          NUM_BUF = 2,
  parameter logic [11:0] OFFSET  = 12'h15C
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_BUF-1:0] buf_occ_i,
  input  logic               xact_busy_i,
  output logic               flush_o
);
  logic any_occ, set_req, req;

  tt_occ_reduce #(.NUM_BUF(NUM_BUF)) u_occ (
    .occ_i (buf_occ_i),
    .any_o (any_occ)
  );

  tt_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(OFFSET)) u_dec (
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .status_i  (any_occ),
    .req_i     (req),
    .set_req_o (set_req),
    .rdata_o   (rdata_o)
  );

  tt_flush_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_req_i (set_req),
    .busy_i    (xact_busy_i),
    .any_occ_i (any_occ),
    .req_o     (req),
    .flush_o   (flush_o)
  );
endmodule

// File: rtl/tt_flush_reg_chk.sv
module tt_flush_reg_chk #(
  parameter int NUM_BUF = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic               set_req,
  input logic               req,
  input logic [NUM_BUF-1:0] buf_occ_i,
  input logic               xact_busy_i,
  input logic               flush_o
);
  assert_flush_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !xact_busy_i);
  assert_flush_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
  assert_flush_needs_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> req);
  assert_clear_when_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req) |-> $past(buf_occ_i == '0));
  assert_set_by_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req) |-> $past(we_i && set_req));
endmodule

bind tt_flush_reg tt_flush_reg_chk #(.NUM_BUF(NUM_BUF)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .set_req     (set_req),
  .req         (req),
  .buf_occ_i   (buf_occ_i),
  .xact_busy_i (xact_busy_i),
  .flush_o     (flush_o)
);

// File: tb/tb_tt_flush_reg.sv
`timescale 1ns/1ps
module tb_tt_flush_reg;
  localparam logic [11:0] REG = 12'h15C;

  logic        clk = 0, rst_n = 0;
  logic [11:0] addr = '0;
  logic        we = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  occ = '0;
  logic        busy = 0;
  logic        flush;
  int          errors = 0, checks = 0, pulses = 0;

  always #10 clk = ~clk;  // 50 MHz

  tt_flush_reg dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .buf_occ_i(occ), .xact_busy_i(busy), .flush_o(flush)
  );

  always @(posedge clk) if (rst_n && flush) pulses++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0; wdata = '0; addr = REG;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata; addr = REG;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(REG, d);
    chk("R1 reg", d, 32'h0);
    chk("R1 flush", {31'b0, flush}, 32'h0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    occ = 2'b01; rd(REG, d); chk("R2 occ01", d, 32'h1);
    occ = 2'b10; rd(REG, d); chk("R2 occ10", d, 32'h1);
    occ = 2'b00; rd(REG, d); chk("R2 occ00", d, 32'h0);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    int p0 = pulses;
    occ = 2'b11;
    wr(12'h158, 32'hFFFF_FFFF);
    rd(REG, d);      chk("R8 other-addr write", d, 32'h1);
    rd(12'h158, d);  chk("R8 other-addr read", d, 32'h0);
    rd(12'h15D, d);  chk("R8 near-addr read", d, 32'h0);
    chk("R8 no pulse", pulses, p0);
    occ = 2'b00;
  endtask

  task automatic t_write_zero;
    logic [31:0] d;
    int p0 = pulses;
    wr(REG, 32'hFFFF_FFFD);
    rd(REG, d); chk("R7 bit1 stays 0", d, 32'h0);
    repeat (2) @(negedge clk);
    chk("R7 no pulse", pulses, p0);
  endtask

  task automatic t_flush_now;
    logic [31:0] d;
    int p0 = pulses;
    occ = 2'b11;
    wr(REG, 32'h2);
    chk("R4 pulse now", {31'b0, flush}, 32'h1);
    rd(REG, d); chk("R3 req set", d, 32'h3);
    @(negedge clk);
    chk("R4 one pulse", pulses, p0 + 1);
    chk("R4 pulse ended", {31'b0, flush}, 32'h0);
    repeat (3) @(negedge clk);
    rd(REG, d); chk("R5 held while occupied", d, 32'h3);
    wr(REG, 32'h2);
    repeat (2) @(negedge clk);
    chk("R6 no second pulse", pulses, p0 + 1);
    rd(REG, d); chk("R6 req still set", d, 32'h3);
    occ = 2'b00;
    @(negedge clk);
    rd(REG, d); chk("R5 self-clear", d, 32'h0);
  endtask

  task automatic t_flush_postponed;
    logic [31:0] d;
    int p0 = pulses;
    occ = 2'b01; busy = 1;
    wr(REG, 32'h2);
    for (int i = 0; i < 5; i++) begin
      chk("R4 held while busy", {31'b0, flush}, 32'h0);
      @(negedge clk);
    end
    chk("R4 no pulse while busy", pulses, p0);
    rd(REG, d); chk("R5 pending while busy", d, 32'h3);
    busy = 0; #1;
    chk("R4 pulse on idle", {31'b0, flush}, 32'h1);
    @(negedge clk);
    chk("R4 one delayed pulse", pulses, p0 + 1);
    occ = 2'b00;
    @(negedge clk);
    rd(REG, d); chk("R5 clear after drain", d, 32'h0);
  endtask

  task automatic t_flush_empty;
    logic [31:0] d;
    int p0 = pulses;
    wr(REG, 32'h2);
    chk("R4 pulse empty", {31'b0, flush}, 32'h1);
    repeat (2) @(negedge clk);
    rd(REG, d); chk("R5 empty clears in two edges", d, 32'h0);
    chk("R4 count empty", pulses, p0 + 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_status();
        t_reserved();
        t_write_zero();
        t_flush_now();
        t_flush_postponed();
        t_flush_empty();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule